// File: doc/BRIEF.md
# Multicycle Processor Sequencing Controller

This block is the control sequencer for a processor datapath in which one memory holds both instructions and data, and one ALU does every add, subtract and function-coded operation. Each instruction is split into steps of one clock each. The controller is a Moore machine: every datapath select, enable and write strobe comes from the current state alone. The inputs that steer it are the 6-bit opcode held in the instruction register and an overflow flag from the ALU. Register-to-register operations, word loads, word stores, equal-compare branches and jumps are supported. These take between three and five cycles and share their first two steps.

There are twelve states. FETCH reads memory at the PC, loads the instruction register and advances the PC by four. FETCH always goes to DECODE. DECODE adds the shifted offset to the PC so the branch target is ready in the ALU output register, then branches on the opcode:
- loads and stores go to MADDR;
- register ops go to EXEC;
- branches go to BRANCH;
- jumps go to JUMP;
- any other code goes to XUNDEF.

MADDR forms base plus offset, then goes to MREAD for a load or to MWRITE for a store. MREAD goes to MWB. EXEC goes to RWB, or to XOVF when the ALU flags overflow. MWB, MWRITE, RWB, BRANCH, JUMP, XUNDEF and XOVF all return to FETCH.

The two exception states point the ALU at PC minus four and strobe the exception-PC and cause registers, each with its own cause code. They also load the PC from a fixed handler vector. A synchronous reset puts the machine in FETCH.

Top module: `mcc_ctrl`

## Requirements
- R1: While reset is high at a clock edge, the next state is FETCH, and the outputs show the FETCH pattern.
- R2: FETCH drives mem_rd_o=1, ir_ld_o=1, mem_addr_sel_o=0, alu_a_sel_o=0, alu_b_sel_o=01, alu_op_o=00 (add), pc_src_o=00 and pc_ld_o=1. It always moves to DECODE.
- R3: DECODE drives alu_a_sel_o=0, alu_b_sel_o=11 and alu_op_o=00, and it asserts no write strobe.
- R4: From DECODE, the opcode selects the next state. Opcodes 100011 (load) and 101011 (store) go to MADDR. Opcode 000000 (register op) goes to EXEC. Opcode 000100 (branch) goes to BRANCH. Opcode 000010 (jump) goes to JUMP.
- R5: MADDR drives alu_a_sel_o=1, alu_b_sel_o=10 and alu_op_o=00. For a load it moves to MREAD, which drives mem_rd_o=1 and mem_addr_sel_o=1. MREAD moves to MWB, which drives rf_we_o=1, wb_src_o=1 and dst_sel_o=0. A load takes 5 cycles.
- R6: For a store, MADDR moves to MWRITE, which drives mem_wr_o=1 and mem_addr_sel_o=1. A store takes 4 cycles.
- R7: EXEC drives alu_a_sel_o=1, alu_b_sel_o=00 and alu_op_o=10. Without overflow it moves to RWB, which drives rf_we_o=1, dst_sel_o=1 and wb_src_o=0. A register op takes 4 cycles.
- R8: BRANCH drives alu_a_sel_o=1, alu_b_sel_o=00, alu_op_o=01, pc_ld_if_eq_o=1 and pc_src_o=01. A branch takes 3 cycles.
- R9: JUMP drives pc_ld_o=1 and pc_src_o=10. A jump takes 3 cycles.
- R10: Any opcode not listed in R4 moves DECODE to XUNDEF. XUNDEF drives epc_ld_o=1, cause_ld_o=1, cause_code_o=0, pc_ld_o=1, pc_src_o=11, alu_a_sel_o=0, alu_b_sel_o=01 and alu_op_o=01 (PC minus four), then returns to FETCH after 3 cycles in total.
- R11: ovf_i high in EXEC moves the machine to XOVF instead of RWB. XOVF drives the same pattern as XUNDEF but with cause_code_o=1, and no register write occurs. ovf_i in any other state has no effect.
- R12: In every state, every output not named for that state in R2 to R11 is 0.
- R13: Reset raised in the middle of an instruction returns the machine to FETCH at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode_i | input | 6 | Opcode field of the instruction register |
| ovf_i | input | 1 | ALU overflow flag |
| mem_addr_sel_o | output | 1 | Memory address select: 0 PC, 1 ALU output register |
| mem_rd_o | output | 1 | Memory read |
| mem_wr_o | output | 1 | Memory write |
| ir_ld_o | output | 1 | Instruction register load |
| wb_src_o | output | 1 | Register write data: 0 ALU output, 1 memory data |
| pc_ld_o | output | 1 | Unconditional PC load |
| pc_ld_if_eq_o | output | 1 | PC load when the ALU zero flag is set |
| pc_src_o | output | 2 | PC source: 00 ALU, 01 ALU output register, 10 jump target, 11 handler vector |
| alu_op_o | output | 2 | ALU operation: 00 add, 01 subtract, 10 from function field |
| alu_a_sel_o | output | 1 | ALU operand A: 0 PC, 1 register A |
| alu_b_sel_o | output | 2 | ALU operand B: 00 register B, 01 constant 4, 10 immediate, 11 shifted immediate |
| dst_sel_o | output | 1 | Destination register: 0 rt field, 1 rd field |
| rf_we_o | output | 1 | Register file write enable |
| epc_ld_o | output | 1 | Exception PC register load |
| cause_ld_o | output | 1 | Cause register load |
| cause_code_o | output | 1 | Cause value: 0 undefined opcode, 1 overflow |

## Verification
The assertions assume the opcode is stable from DECODE until the machine is back in FETCH, as it is when the instruction register loads only in FETCH. They also assume ovf_i is only a real flag while the function-coded ALU operation is selected. The stimulus changes the opcode only in FETCH cycles. It raises ovf_i deliberately in other states only to show that the flag is ignored there. One mid-instruction reset is applied at a falling edge. Every instruction class, including undefined codes and overflowing register ops, is run, and its cycle count is compared against the expected length.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    typedef enum logic [3:0] {
        ST_FETCH,
        ST_DECODE,
        ST_MADDR,
        ST_MREAD,
        ST_MWB,
        ST_MWRITE,
        ST_EXEC,
        ST_RWB,
        ST_BRANCH,
        ST_JUMP,
        ST_XUNDEF,
        ST_XOVF
    } state_t;

    typedef enum logic [2:0] {
        CL_REG,
        CL_LOAD,
        CL_STORE,
        CL_BRANCH,
        CL_JUMP,
        CL_BAD
    } opclass_t;

    // PC source select codes
    localparam logic [1:0] PCS_ALU    = 2'b00;
    localparam logic [1:0] PCS_ALUREG = 2'b01;
    localparam logic [1:0] PCS_JUMP   = 2'b10;
    localparam logic [1:0] PCS_VECTOR = 2'b11;

    // ALU operation codes
    localparam logic [1:0] AOP_ADD  = 2'b00;
    localparam logic [1:0] AOP_SUB  = 2'b01;
    localparam logic [1:0] AOP_FUNC = 2'b10;

    // ALU operand B select codes
    localparam logic [1:0] BS_REG   = 2'b00;
    localparam logic [1:0] BS_FOUR  = 2'b01;
    localparam logic [1:0] BS_IMM   = 2'b10;
    localparam logic [1:0] BS_BROFF = 2'b11;

    typedef struct packed {
        logic       mem_addr_sel;
        logic       mem_rd;
        logic       mem_wr;
        logic       ir_ld;
        logic       wb_src;
        logic       pc_ld;
        logic       pc_ld_if_eq;
        logic [1:0] pc_src;
        logic [1:0] alu_op;
        logic       alu_a_sel;
        logic [1:0] alu_b_sel;
        logic       dst_sel;
        logic       rf_we;
        logic       epc_ld;
        logic       cause_ld;
        logic       cause_code;
    } ctrl_t;

    localparam ctrl_t CTRL_IDLE = '0;

endpackage

// File: rtl/mcc_opclass.sv
module mcc_opclass
    import mcc_pkg::*;
#(
    parameter int              OP_W      = 6,
    parameter logic [OP_W-1:0] OP_REG    = 6'b000000,
    parameter logic [OP_W-1:0] OP_LOAD   = 6'b100011,
    parameter logic [OP_W-1:0] OP_STORE  = 6'b101011,
    parameter logic [OP_W-1:0] OP_BRANCH = 6'b000100,
    parameter logic [OP_W-1:0] OP_JUMP   = 6'b000010
) (
    input  logic [OP_W-1:0] opcode,
    output opclass_t        opclass
);

    always_comb begin
        if (opcode == OP_REG)
            opclass = CL_REG;
        else if (opcode == OP_LOAD)
            opclass = CL_LOAD;
        else if (opcode == OP_STORE)
            opclass = CL_STORE;
        else if (opcode == OP_BRANCH)
            opclass = CL_BRANCH;
        else if (opcode == OP_JUMP)
            opclass = CL_JUMP;
        else
            opclass = CL_BAD;
    end

endmodule

// File: rtl/mcc_next_state.sv
module mcc_next_state
    import mcc_pkg::*;
(
    input  state_t   cur,
    input  opclass_t opclass,
    input  logic     ovf,
    output state_t   nxt
);

    always_comb begin
        nxt = ST_FETCH;
        unique case (cur)
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: begin
                unique case (opclass)
                    CL_LOAD,
                    CL_STORE:  nxt = ST_MADDR;
                    CL_REG:    nxt = ST_EXEC;
                    CL_BRANCH: nxt = ST_BRANCH;
                    CL_JUMP:   nxt = ST_JUMP;
                    default:   nxt = ST_XUNDEF;
                endcase
            end
            ST_MADDR:  nxt = (opclass == CL_LOAD) ? ST_MREAD : ST_MWRITE;
            ST_MREAD:  nxt = ST_MWB;
            ST_EXEC:   nxt = ovf ? ST_XOVF : ST_RWB;
            ST_MWB,
            ST_MWRITE,
            ST_RWB,
            ST_BRANCH,
            ST_JUMP,
            ST_XUNDEF,
            ST_XOVF:   nxt = ST_FETCH;
            default:   nxt = ST_FETCH;
        endcase
    end

endmodule

// File: rtl/mcc_outputs.sv
module mcc_outputs
    import mcc_pkg::*;
(
    input  state_t cur,
    output ctrl_t  ctl
);

    always_comb begin
        ctl = CTRL_IDLE;
        unique case (cur)
            ST_FETCH: begin
                ctl.mem_rd    = 1'b1;
                ctl.ir_ld     = 1'b1;
                ctl.alu_b_sel = BS_FOUR;
                ctl.alu_op    = AOP_ADD;
                ctl.pc_src    = PCS_ALU;
                ctl.pc_ld     = 1'b1;
            end
            ST_DECODE: begin
                ctl.alu_b_sel = BS_BROFF;
                ctl.alu_op    = AOP_ADD;
            end
            ST_MADDR: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_b_sel = BS_IMM;
                ctl.alu_op    = AOP_ADD;
            end
            ST_MREAD: begin
                ctl.mem_rd       = 1'b1;
                ctl.mem_addr_sel = 1'b1;
            end
            ST_MWB: begin
                ctl.rf_we  = 1'b1;
                ctl.wb_src = 1'b1;
            end
            ST_MWRITE: begin
                ctl.mem_wr       = 1'b1;
                ctl.mem_addr_sel = 1'b1;
            end
            ST_EXEC: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_b_sel = BS_REG;
                ctl.alu_op    = AOP_FUNC;
            end
            ST_RWB: begin
                ctl.rf_we   = 1'b1;
                ctl.dst_sel = 1'b1;
            end
            ST_BRANCH: begin
                ctl.alu_a_sel   = 1'b1;
                ctl.alu_b_sel   = BS_REG;
                ctl.alu_op      = AOP_SUB;
                ctl.pc_ld_if_eq = 1'b1;
                ctl.pc_src      = PCS_ALUREG;
            end
            ST_JUMP: begin
                ctl.pc_ld  = 1'b1;
                ctl.pc_src = PCS_JUMP;
            end
            ST_XUNDEF,
            ST_XOVF: begin
                ctl.alu_b_sel  = BS_FOUR;
                ctl.alu_op     = AOP_SUB;
                ctl.epc_ld     = 1'b1;
                ctl.cause_ld   = 1'b1;
                ctl.cause_code = (cur == ST_XOVF);
                ctl.pc_ld      = 1'b1;
                ctl.pc_src     = PCS_VECTOR;
            end
            default: ctl = CTRL_IDLE;
        endcase
    end

endmodule

// File: rtl/mcc_ctrl.sv
module mcc_ctrl
    import mcc_pkg::*;
#(
    parameter int              OP_W      = 6,
    parameter logic [OP_W-1:0] OP_REG    = 6'b000000,
    parameter logic [OP_W-1:0] OP_LOAD   = 6'b100011,
    parameter logic [OP_W-1:0] OP_STORE  = 6'b101011,
    parameter logic [OP_W-1:0] OP_BRANCH = 6'b000100,
    parameter logic [OP_W-1:0] OP_JUMP   = 6'b000010
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] opcode_i,
    input  logic            ovf_i,
    output logic            mem_addr_sel_o,
    output logic            mem_rd_o,
    output logic            mem_wr_o,
    output logic            ir_ld_o,
    output logic            wb_src_o,
    output logic            pc_ld_o,
    output logic            pc_ld_if_eq_o,
    output logic [1:0]      pc_src_o,
    output logic [1:0]      alu_op_o,
    output logic            alu_a_sel_o,
    output logic [1:0]      alu_b_sel_o,
    output logic            dst_sel_o,
    output logic            rf_we_o,
    output logic            epc_ld_o,
    output logic            cause_ld_o,
    output logic            cause_code_o
);

    state_t   state_q;
    state_t   state_d;
    opclass_t opclass;
    ctrl_t    ctl;

    mcc_opclass #(
        .OP_W     (OP_W),
        .OP_REG   (OP_REG),
        .OP_LOAD  (OP_LOAD),
        .OP_STORE (OP_STORE),
        .OP_BRANCH(OP_BRANCH),
        .OP_JUMP  (OP_JUMP)
    ) u_opclass (
        .opcode (opcode_i),
        .opclass(opclass)
    );

    mcc_next_state u_next (
        .cur    (state_q),
        .opclass(opclass),
        .ovf    (ovf_i),
        .nxt    (state_d)
    );

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_FETCH;
        else
            state_q <= state_d;
    end

    mcc_outputs u_out (
        .cur(state_q),
        .ctl(ctl)
    );

    assign mem_addr_sel_o = ctl.mem_addr_sel;
    assign mem_rd_o       = ctl.mem_rd;
    assign mem_wr_o       = ctl.mem_wr;
    assign ir_ld_o        = ctl.ir_ld;
    assign wb_src_o       = ctl.wb_src;
    assign pc_ld_o        = ctl.pc_ld;
    assign pc_ld_if_eq_o  = ctl.pc_ld_if_eq;
    assign pc_src_o       = ctl.pc_src;
    assign alu_op_o       = ctl.alu_op;
    assign alu_a_sel_o    = ctl.alu_a_sel;
    assign alu_b_sel_o    = ctl.alu_b_sel;
    assign dst_sel_o      = ctl.dst_sel;
    assign rf_we_o        = ctl.rf_we;
    assign epc_ld_o       = ctl.epc_ld;
    assign cause_ld_o     = ctl.cause_ld;
    assign cause_code_o   = ctl.cause_code;

endmodule

// File: rtl/mcc_ctrl_chk.sv
module mcc_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       ovf_i,
    input logic       mem_addr_sel_o,
    input logic       mem_rd_o,
    input logic       mem_wr_o,
    input logic       ir_ld_o,
    input logic       wb_src_o,
    input logic       pc_ld_o,
    input logic [1:0] alu_op_o,
    input logic       alu_a_sel_o,
    input logic [1:0] alu_b_sel_o,
    input logic       dst_sel_o,
    input logic       rf_we_o,
    input logic       epc_ld_o,
    input logic       cause_ld_o,
    input logic       cause_code_o
);

    // R2
    fetch_to_decode_chk: assert property (@(posedge clk) disable iff (rst)
        ir_ld_o |=> (alu_b_sel_o == 2'b11 && !alu_a_sel_o && !pc_ld_o));

    // R5
    load_writeback_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_o && mem_addr_sel_o) |=> (rf_we_o && wb_src_o && !dst_sel_o));

    // R7
    reg_wb_origin_chk: assert property (@(posedge clk) disable iff (rst)
        (rf_we_o && dst_sel_o) |-> $past(alu_op_o == 2'b10 && !ovf_i));

    // R11
    overflow_trap_chk: assert property (@(posedge clk) disable iff (rst)
        (alu_op_o == 2'b10 && alu_a_sel_o && ovf_i) |=>
            (epc_ld_o && cause_ld_o && cause_code_o && !rf_we_o));

    // R10
    trap_return_chk: assert property (@(posedge clk) disable iff (rst)
        epc_ld_o |=> ir_ld_o);

    // R12
    one_access_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_rd_o, mem_wr_o, rf_we_o}));

    // R13
    reset_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ir_ld_o && mem_rd_o && !mem_addr_sel_o));

endmodule

bind mcc_ctrl mcc_ctrl_chk u_chk (.*);

// File: tb/mcc_ctrl_tb.sv
`timescale 1ns/1ps
module mcc_ctrl_tb;

    localparam logic [5:0] C_REG = 6'b000000;
    localparam logic [5:0] C_LD  = 6'b100011;
    localparam logic [5:0] C_ST  = 6'b101011;
    localparam logic [5:0] C_BEQ = 6'b000100;
    localparam logic [5:0] C_JMP = 6'b000010;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'b0;
    logic       ovf = 1'b0;

    logic       mem_addr_sel_o, mem_rd_o, mem_wr_o, ir_ld_o, wb_src_o;
    logic       pc_ld_o, pc_ld_if_eq_o, alu_a_sel_o, dst_sel_o, rf_we_o;
    logic       epc_ld_o, cause_ld_o, cause_code_o;
    logic [1:0] pc_src_o, alu_op_o, alu_b_sel_o;

    always #2 clk = ~clk;

    mcc_ctrl u_dut (
        .clk           (clk),
        .rst           (rst),
        .opcode_i      (opcode),
        .ovf_i         (ovf),
        .mem_addr_sel_o(mem_addr_sel_o),
        .mem_rd_o      (mem_rd_o),
        .mem_wr_o      (mem_wr_o),
        .ir_ld_o       (ir_ld_o),
        .wb_src_o      (wb_src_o),
        .pc_ld_o       (pc_ld_o),
        .pc_ld_if_eq_o (pc_ld_if_eq_o),
        .pc_src_o      (pc_src_o),
        .alu_op_o      (alu_op_o),
        .alu_a_sel_o   (alu_a_sel_o),
        .alu_b_sel_o   (alu_b_sel_o),
        .dst_sel_o     (dst_sel_o),
        .rf_we_o       (rf_we_o),
        .epc_ld_o      (epc_ld_o),
        .cause_ld_o    (cause_ld_o),
        .cause_code_o  (cause_code_o)
    );

    int n_run  = 0;
    int n_fail = 0;
    int ref_st = 0;   // 0 fetch,1 decode,2 addr,3 read,4 load wb,5 write,6 exec,7 reg wb,8 branch,9 jump,10 undef,11 ovf
    bit armed  = 1'b0;
    bit done   = 1'b0;

    function automatic int ref_next(int s, logic [5:0] op, logic ov);
        case (s)
            0: return 1;
            1: begin
                if (op == C_LD || op == C_ST) return 2;
                if (op == C_REG) return 6;
                if (op == C_BEQ) return 8;
                if (op == C_JMP) return 9;
                return 10;
            end
            2: return (op == C_LD) ? 3 : 5;
            3: return 4;
            6: return ov ? 11 : 7;
            default: return 0;
        endcase
    endfunction

    // packing order: addr_sel rd wr ir wb_src pc_ld pc_eq pc_src alu_op a_sel b_sel dst we epc cause code
    function automatic logic [18:0] ref_out(int s);
        logic as = 0, rd = 0, wr = 0, ir = 0, ws = 0, pl = 0, pq = 0;
        logic asel = 0, dst = 0, we = 0, epc = 0, cl = 0, cc = 0;
        logic [1:0] ps = 0, ao = 0, bs = 0;
        case (s)
            0: begin rd = 1; ir = 1; bs = 2'b01; pl = 1; end
            1: bs = 2'b11;
            2: begin asel = 1; bs = 2'b10; end
            3: begin rd = 1; as = 1; end
            4: begin we = 1; ws = 1; end
            5: begin wr = 1; as = 1; end
            6: begin asel = 1; ao = 2'b10; end
            7: begin we = 1; dst = 1; end
            8: begin asel = 1; ao = 2'b01; pq = 1; ps = 2'b01; end
            9: begin pl = 1; ps = 2'b10; end
            10, 11: begin
                bs = 2'b01; ao = 2'b01; epc = 1; cl = 1; pl = 1; ps = 2'b11;
                cc = (s == 11);
            end
            default: ;
        endcase
        return {as, rd, wr, ir, ws, pl, pq, ps, ao, asel, bs, dst, we, epc, cl, cc};
    endfunction

    function automatic string req_of(int s);
        case (s)
            0: return "R2";
            1: return "R3";
            2, 3, 4: return "R5";
            5: return "R6";
            6, 7: return "R7";
            8: return "R8";
            9: return "R9";
            10: return "R10";
            default: return "R11";
        endcase
    endfunction

    always @(posedge clk) begin
        armed  <= 1'b1;
        ref_st <= rst ? 0 : ref_next(ref_st, opcode, ovf);
    end

    // per-cycle compare of the full output vector (also covers R12 defaults)
    always @(negedge clk) begin
        if (armed && !done) begin
            logic [18:0] act;
            logic [18:0] exp;
            act = {mem_addr_sel_o, mem_rd_o, mem_wr_o, ir_ld_o, wb_src_o, pc_ld_o,
                   pc_ld_if_eq_o, pc_src_o, alu_op_o, alu_a_sel_o, alu_b_sel_o,
                   dst_sel_o, rf_we_o, epc_ld_o, cause_ld_o, cause_code_o};
            exp = ref_out(ref_st);
            n_run++;
            if (act !== exp) begin
                n_fail++;
                $display("FAIL %s/R12 state %0d outputs act=%b exp=%b",
                         rst ? "R1" : req_of(ref_st), ref_st, act, exp);
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // called at a falling edge while in fetch; returns at the falling edge of the next fetch
    task automatic run_instr(input logic [5:0] op, input logic ov_exec,
                             input logic ov_other, input int exp_len, input string tag);
        int n;
        opcode = op;
        ovf    = ov_other;
        n      = 1;
        forever begin
            @(negedge clk);
            if (ref_st == 0) break;
            n++;
            ovf = (ref_st == 6) ? ov_exec : ov_other;
        end
        ovf = 1'b0;
        check(n == exp_len, tag, n, exp_len);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset holds the fetch pattern
        check(ir_ld_o && mem_rd_o && pc_ld_o && !rf_we_o && alu_b_sel_o == 2'b01,
              "R1 reset pattern", int'(ir_ld_o), 1);
        rst = 1'b0;

        run_instr(C_LD,  1'b0, 1'b0, 5, "R5 load length");
        run_instr(C_ST,  1'b0, 1'b0, 4, "R6 store length");
        run_instr(C_REG, 1'b0, 1'b0, 4, "R7 reg op length");
        run_instr(C_BEQ, 1'b0, 1'b0, 3, "R8 branch length");
        run_instr(C_JMP, 1'b0, 1'b0, 3, "R9 jump length");
        run_instr(6'b111111, 1'b0, 1'b0, 3, "R10 undefined 111111");
        run_instr(6'b001000, 1'b0, 1'b0, 3, "R10 undefined 001000");
        run_instr(6'b100011 ^ 6'b000001, 1'b0, 1'b0, 3, "R4 near-load code is undefined");
        run_instr(C_REG, 1'b1, 1'b0, 4, "R11 overflow trap length");
        run_instr(C_LD,  1'b0, 1'b1, 5, "R11 overflow ignored in load");
        run_instr(C_REG, 1'b0, 1'b1, 4, "R11 overflow ignored outside exec");
        run_instr(C_BEQ, 1'b0, 1'b1, 3, "R11 overflow ignored in branch");
        run_instr(C_ST,  1'b0, 1'b0, 4, "R4 store dispatch again");

        // R13: reset in the middle of a load
        opcode = C_LD;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(ir_ld_o && !mem_addr_sel_o && !rf_we_o, "R13 reset mid-load", int'(ir_ld_o), 1);
        rst = 1'b0;
        run_instr(C_JMP, 1'b0, 1'b0, 3, "R13 resume after reset");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule